// File: doc/BRIEF.md
# Horizontal-Blank Video Memory DMA

This block copies a block of bytes from system memory into video memory, sixteen bytes at a time. Each sixteen-byte chunk is moved only while the display sits in its horizontal blanking interval on a visible line, and never more than once per line. The copying therefore spreads across many lines without ever touching video memory while the display is drawing.

The CPU issues a start command that carries four things. These are a source address, a destination address inside the video memory window, a chunk count and a mode bit. The engine watches the current line number and the two-bit display mode. For each chunk it reads bytes through a byte-wide memory read port that has one cycle of latency. Each byte is written one cycle after its read, through a video-memory write port that carries a bank select. A busy flag and the remaining byte count are reported at all times.

Top module: `hbdma_engine`

## Requirements
- R1: After reset `busy` is 0, `remaining` is 0, and neither `mem_rd_en` nor `vram_we` is asserted.
- R2: A start with `start_hblank`=1 loads `remaining` with (`start_chunks`+1)*16, visible in the cycle after the start. It also clears bits [3:0] of both the source and the destination address.
- R3: A chunk reads 16 consecutive ascending addresses from the source, one per cycle. Each byte is written one cycle after its read, to video offset (destination − 0x8000) plus its index. The written value is the data that was read.
- R4: No chunk starts while `line` is 143 or greater.
- R5: No chunk starts unless `disp_mode` equals 2'b00 (horizontal blank).
- R6: At most one chunk is moved per line value. After a start, the first eligible line triggers a chunk even if it equals the line of an earlier chunk.
- R7: After each chunk, `remaining` drops by 16, and the next chunk's source and destination are each 16 higher.
- R8: `vram_bank` equals the `bank_sel` value sampled when the chunk started, for the whole chunk.
- R9: `busy` equals (`remaining` != 0). It falls in the cycle after the final write, and no reads happen once `remaining` is 0.
- R10: A start with `start_hblank`=0 sets `remaining` to 0 and moves no data.
- R11: A start that arrives during a chunk aborts that chunk at once: no read or write follows in the next cycle. The new parameters are then loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle start command |
| start_hblank | input | 1 | 1 selects line-paced transfer, 0 loads nothing |
| start_src | input | 16 | Source address |
| start_dst | input | 16 | Destination address in the video window |
| start_chunks | input | 7 | Chunk count minus one |
| bank_sel | input | 1 | Currently selected video memory bank |
| line | input | 8 | Current display line |
| disp_mode | input | 2 | Display mode field, 2'b00 is horizontal blank |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the strobe |
| vram_we | output | 1 | Video memory write strobe |
| vram_bank | output | 1 | Video memory bank of the write |
| vram_addr | output | 13 | Offset into the video memory window |
| vram_wdata | output | 8 | Write data |
| busy | output | 1 | Transfer still pending |
| remaining | output | 12 | Bytes left to move |

## Verification
The two functions that can meet in one cycle are a CPU start command and a chunk already in flight. The bench provokes this by issuing a new start six cycles into a chunk. It then checks that the very next cycle shows neither a read nor a write and that `remaining` holds the new length. It also checks that the next chunk starts from the new source, on a line equal to the aborted one. A second meeting point is the completion of one chunk against the line record. To judge it, the bench holds the same line in horizontal blank after a chunk and requires silence, then advances the line and requires exactly one further chunk.

// File: rtl/hbdma_pkg.sv
package hbdma_pkg;
    localparam int ADDR_W      = 16;
    localparam int DATA_W      = 8;
    localparam int VOFS_W      = 13;
    localparam int CHUNKS_W    = 7;
    localparam int BURST_BYTES = 16;
    localparam int BEAT_W      = $clog2(BURST_BYTES);
    localparam int LEN_W       = CHUNKS_W + BEAT_W + 1;
    localparam int LINE_W      = 8;
    localparam int LINE_LIMIT  = 143;
    localparam logic [ADDR_W-1:0] VRAM_BASE = 16'h8000;
    localparam logic [1:0] MODE_HBLANK = 2'b00;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [VOFS_W-1:0] dst;
        logic [LEN_W-1:0]  left;
    } xfer_t;

    function automatic logic [LEN_W-1:0] chunk_bytes(input logic [CHUNKS_W-1:0] n);
        return (LEN_W'(n) + LEN_W'(1)) << BEAT_W;
    endfunction

    function automatic logic [ADDR_W-1:0] align_chunk(input logic [ADDR_W-1:0] a);
        return a & ~ADDR_W'(BURST_BYTES - 1);
    endfunction
endpackage

// File: rtl/hbdma_gate.sv
module hbdma_gate
    import hbdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              ready,
    input  logic [LINE_W-1:0] line,
    input  logic [1:0]        disp_mode,
    output logic              go
);
    logic [LINE_W-1:0] last_line_q;
    logic              last_valid_q;
    logic              new_line;

    always_comb new_line = !last_valid_q || (line != last_line_q);

    assign go = ready && !arm && new_line &&
                (line < LINE_W'(LINE_LIMIT)) && (disp_mode == MODE_HBLANK);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_valid_q <= 1'b0;
            last_line_q  <= '0;
        end else if (arm) begin
            last_valid_q <= 1'b0;
        end else if (go) begin
            last_valid_q <= 1'b1;
            last_line_q  <= line;
        end
    end

    // R6: the line of every chunk is recorded
    a_r6_line_recorded: assert property (@(posedge clk) disable iff (rst)
        go |=> (last_valid_q && last_line_q == $past(line)));
endmodule

// File: rtl/hbdma_burst.sv
module hbdma_burst
    import hbdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              abort,
    input  logic              bank_in,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [VOFS_W-1:0] dst_base,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              we,
    output logic              wbank,
    output logic [VOFS_W-1:0] waddr,
    output logic [DATA_W-1:0] wdata,
    output logic              done,
    output logic              idle
);
    logic              reading_q;
    logic [BEAT_W-1:0] beat_q;
    logic              wr_pend_q;
    logic              wr_last_q;
    logic [VOFS_W-1:0] wr_off_q;
    logic              bank_q;
    logic              last_beat;

    assign last_beat = (beat_q == BEAT_W'(BURST_BYTES - 1));
    assign rd_en     = reading_q;
    assign rd_addr   = src_base + ADDR_W'(beat_q);
    assign we        = wr_pend_q;
    assign waddr     = wr_off_q;
    assign wdata     = rd_data;
    assign wbank     = bank_q;
    assign done      = wr_pend_q && wr_last_q;
    assign idle      = !reading_q && !wr_pend_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            reading_q <= 1'b0;
            beat_q    <= '0;
            wr_pend_q <= 1'b0;
            wr_last_q <= 1'b0;
            wr_off_q  <= '0;
            if (rst) bank_q <= 1'b0;
        end else begin
            wr_pend_q <= reading_q;
            wr_last_q <= reading_q && last_beat;
            wr_off_q  <= dst_base + VOFS_W'(beat_q);
            if (go) begin
                reading_q <= 1'b1;
                beat_q    <= '0;
                bank_q    <= bank_in;
            end else if (reading_q) begin
                beat_q <= beat_q + BEAT_W'(1);
                if (last_beat) reading_q <= 1'b0;
            end
        end
    end

    // R3: every write is preceded by a read one cycle earlier
    a_r3_write_after_read: assert property (@(posedge clk) disable iff (rst)
        we |-> $past(rd_en));
    // R3: reads within a chunk step up by one
    a_r3_ascending: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + ADDR_W'(1)));
    // R8: bank stays fixed while writes are in flight
    a_r8_bank_held: assert property (@(posedge clk) disable iff (rst)
        (we && $past(we)) |-> $stable(wbank));
endmodule

// File: rtl/hbdma_engine.sv
module hbdma_engine
    import hbdma_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                start_hblank,
    input  logic [ADDR_W-1:0]   start_src,
    input  logic [ADDR_W-1:0]   start_dst,
    input  logic [CHUNKS_W-1:0] start_chunks,
    input  logic                bank_sel,
    input  logic [LINE_W-1:0]   line,
    input  logic [1:0]          disp_mode,
    output logic                mem_rd_en,
    output logic [ADDR_W-1:0]   mem_rd_addr,
    input  logic [DATA_W-1:0]   mem_rd_data,
    output logic                vram_we,
    output logic                vram_bank,
    output logic [VOFS_W-1:0]   vram_addr,
    output logic [DATA_W-1:0]   vram_wdata,
    output logic                busy,
    output logic [LEN_W-1:0]    remaining
);
    xfer_t       xfer_q;
    logic        go;
    logic        done;
    logic        idle;
    logic        ready;
    logic [ADDR_W-1:0] dst_rel;

    assign dst_rel   = align_chunk(start_dst) - VRAM_BASE;
    assign ready     = idle && (xfer_q.left != '0);
    assign busy      = (xfer_q.left != '0);
    assign remaining = xfer_q.left;

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_q <= '0;
        end else if (start) begin
            xfer_q.src  <= align_chunk(start_src);
            xfer_q.dst  <= dst_rel[VOFS_W-1:0];
            xfer_q.left <= start_hblank ? chunk_bytes(start_chunks) : '0;
        end else if (done) begin
            xfer_q.src  <= xfer_q.src + ADDR_W'(BURST_BYTES);
            xfer_q.dst  <= xfer_q.dst + VOFS_W'(BURST_BYTES);
            xfer_q.left <= xfer_q.left - LEN_W'(BURST_BYTES);
        end
    end

    hbdma_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .arm       (start),
        .ready     (ready),
        .line      (line),
        .disp_mode (disp_mode),
        .go        (go)
    );

    hbdma_burst u_burst (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .abort    (start),
        .bank_in  (bank_sel),
        .src_base (xfer_q.src),
        .dst_base (xfer_q.dst),
        .rd_data  (mem_rd_data),
        .rd_en    (mem_rd_en),
        .rd_addr  (mem_rd_addr),
        .we       (vram_we),
        .wbank    (vram_bank),
        .waddr    (vram_addr),
        .wdata    (vram_wdata),
        .done     (done),
        .idle     (idle)
    );

    // R4 and R5: a chunk begins only on a visible line in horizontal blank
    a_r4_visible_hblank: assert property (@(posedge clk) disable iff (rst)
        go |-> (line < LINE_W'(LINE_LIMIT) && disp_mode == MODE_HBLANK));
    // R7: outside a start, the count only ever steps down by one chunk
    a_r7_step_down: assert property (@(posedge clk) disable iff (rst)
        (!$past(start) && remaining != $past(remaining))
            |-> (remaining == $past(remaining) - LEN_W'(BURST_BYTES)));
    // R9: nothing is read once the count is exhausted
    a_r9_quiet_when_empty: assert property (@(posedge clk) disable iff (rst)
        (remaining == '0) |-> !mem_rd_en);
    // R11: a start cancels any chunk in flight
    a_r11_abort: assert property (@(posedge clk) disable iff (rst)
        start |=> (!mem_rd_en && !vram_we));
endmodule

// File: tb/hbdma_engine_tb_top.sv
module hbdma_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        start_hblank = 1'b0;
    logic [15:0] start_src = '0;
    logic [15:0] start_dst = '0;
    logic [6:0]  start_chunks = '0;
    logic        bank_sel = 1'b0;
    logic [7:0]  line = 8'd0;
    logic [1:0]  disp_mode = 2'b10;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic [7:0]  mem_rd_data = '0;
    logic        vram_we;
    logic        vram_bank;
    logic [12:0] vram_addr;
    logic [7:0]  vram_wdata;
    logic        busy;
    logic [11:0] remaining;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    hbdma_engine dut_i (
        .clk(clk), .rst(rst), .start(start), .start_hblank(start_hblank),
        .start_src(start_src), .start_dst(start_dst), .start_chunks(start_chunks),
        .bank_sel(bank_sel), .line(line), .disp_mode(disp_mode),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .vram_we(vram_we), .vram_bank(vram_bank), .vram_addr(vram_addr),
        .vram_wdata(vram_wdata), .busy(busy), .remaining(remaining)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        mem_rd_data <= pat(mem_rd_addr);
        if (mem_rd_en) rd_cnt <= rd_cnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_start(input logic [15:0] s, input logic [15:0] d,
                            input logic [6:0] n, input logic hb);
        @(negedge clk);
        start = 1'b1; start_src = s; start_dst = d; start_chunks = n; start_hblank = hb;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Opens horizontal blank on line lv and checks one whole chunk.
    task automatic do_burst(input logic [15:0] s, input logic [12:0] off,
                            input logic bank, input logic [7:0] lv);
        bit rd_ok = 1;
        bit wr_ok = 1;
        logic [31:0] rd_bad = '0;
        logic [31:0] wr_bad = '0;
        @(negedge clk);
        bank_sel = bank; line = lv; disp_mode = 2'b00;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (k == 8) bank_sel = ~bank;
            if (!(mem_rd_en && mem_rd_addr == s + 16'(k))) begin
                if (rd_ok) rd_bad = {15'd0, mem_rd_en, mem_rd_addr};
                rd_ok = 0;
            end
            if (k > 0 && !(vram_we && vram_addr == off + 13'(k - 1) &&
                           vram_wdata == pat(s + 16'(k - 1)) && vram_bank == bank)) begin
                if (wr_ok) wr_bad = {2'd0, vram_we, vram_bank, vram_wdata, 3'd0, vram_addr};
                wr_ok = 0;
            end
        end
        @(negedge clk);
        if (!(vram_we && vram_addr == off + 13'd15 && vram_wdata == pat(s + 16'd15) &&
              vram_bank == bank && !mem_rd_en)) begin
            if (wr_ok) wr_bad = {2'd0, vram_we, vram_bank, vram_wdata, 3'd0, vram_addr};
            wr_ok = 0;
        end
        disp_mode = 2'b10;
        bank_sel = bank;
        chk(rd_ok, "R3 ascending reads", rd_bad, {16'd1, s});
        chk(wr_ok, "R3/R8 writes follow reads", wr_bad, {2'd0, 1'b1, bank, pat(s), 3'd0, off});
    endtask

    task automatic quiet(input int n, input string tag);
        int c0;
        c0 = rd_cnt;
        repeat (n) @(negedge clk);
        chk(rd_cnt == c0, tag, rd_cnt - c0, 0);
    endtask

    typedef struct packed {
        logic [15:0] src;
        logic [15:0] dst;
        logic [6:0]  n;
        logic        bank;
    } vec_t;

    localparam vec_t VEC [0:3] = '{
        {16'h1234, 16'h8567, 7'd1, 1'b0},
        {16'hC00F, 16'h9FFF, 7'd0, 1'b1},
        {16'h4008, 16'h8000, 7'd2, 1'b0},
        {16'h0A50, 16'h9230, 7'd0, 1'b1}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", 32'(busy), 0);
        chk(remaining == 12'd0, "R1 remaining after reset", 32'(remaining), 0);
        chk(!mem_rd_en && !vram_we, "R1 ports idle after reset", {mem_rd_en, vram_we}, 0);

        // Vector table: whole transfers, line numbers reused across transfers (R6)
        foreach (VEC[i]) begin
            logic [15:0] s;
            logic [12:0] off;
            logic [11:0] len;
            s   = VEC[i].src & 16'hFFF0;
            off = 13'((VEC[i].dst & 16'hFFF0) - 16'h8000);
            len = 12'((VEC[i].n + 1) * 16);
            do_start(VEC[i].src, VEC[i].dst, VEC[i].n, 1'b1);
            chk(remaining == len, "R2 length loaded", 32'(remaining), 32'(len));
            chk(busy == 1'b1, "R9 busy while pending", 32'(busy), 1);
            for (int c = 0; c <= int'(VEC[i].n); c++) begin
                do_burst(s + 16'(16 * c), off + 13'(16 * c), VEC[i].bank, 8'(10 + c));
                @(negedge clk);
                chk(remaining == len - 12'(16 * (c + 1)), "R7 count per chunk",
                    32'(remaining), 32'(len - 12'(16 * (c + 1))));
            end
            chk(busy == 1'b0, "R9 busy clears after final write", 32'(busy), 0);
        end

        // R9: exhausted count stays quiet on fresh eligible lines
        line = 8'd50; disp_mode = 2'b00;
        quiet(20, "R9 no reads when empty");
        line = 8'd51;
        quiet(10, "R9 no reads when empty, new line");
        disp_mode = 2'b10;

        // R4: line limit
        do_start(16'h2000, 16'h8100, 7'd0, 1'b1);
        line = 8'd143; disp_mode = 2'b00;
        quiet(20, "R4 no chunk on line 143");
        line = 8'd200;
        quiet(10, "R4 no chunk on line 200");
        disp_mode = 2'b10;
        do_burst(16'h2000, 13'h0100, 1'b0, 8'd142);
        @(negedge clk);
        chk(remaining == 12'd0, "R4 chunk on line 142", 32'(remaining), 0);

        // R5: display mode gating
        do_start(16'h2200, 16'h8300, 7'd0, 1'b1);
        line = 8'd5;
        for (int m = 1; m < 4; m++) begin
            disp_mode = 2'(m);
            quiet(12, "R5 no chunk outside hblank");
        end
        disp_mode = 2'b10;
        do_burst(16'h2200, 13'h0300, 1'b1, 8'd5);
        @(negedge clk);
        chk(remaining == 12'd0, "R5 chunk in hblank", 32'(remaining), 0);

        // R6: one chunk per line
        do_start(16'h2400, 16'h8400, 7'd1, 1'b1);
        do_burst(16'h2400, 13'h0400, 1'b0, 8'd20);
        disp_mode = 2'b00;
        quiet(25, "R6 no second chunk on same line");
        chk(remaining == 12'd16, "R6 count unchanged on same line", 32'(remaining), 16);
        do_burst(16'h2410, 13'h0410, 1'b0, 8'd21);
        @(negedge clk);
        chk(remaining == 12'd0, "R6 chunk on next line", 32'(remaining), 0);

        // R10: start without line-paced mode
        do_start(16'h2600, 16'h8600, 7'd3, 1'b0);
        chk(remaining == 12'd0, "R10 no length loaded", 32'(remaining), 0);
        chk(busy == 1'b0, "R10 busy stays low", 32'(busy), 0);
        line = 8'd60; disp_mode = 2'b00;
        quiet(20, "R10 no data moved");
        disp_mode = 2'b10;

        // R11: start during a chunk in flight
        do_start(16'h2000, 16'h8100, 7'd3, 1'b1);
        @(negedge clk);
        line = 8'd30; disp_mode = 2'b00;
        repeat (6) @(negedge clk);
        start = 1'b1; start_src = 16'h3000; start_dst = 16'h8200;
        start_chunks = 7'd0; start_hblank = 1'b1; disp_mode = 2'b10;
        @(negedge clk);
        start = 1'b0;
        chk(!mem_rd_en && !vram_we, "R11 chunk aborted", {mem_rd_en, vram_we}, 0);
        chk(remaining == 12'd16, "R11 new length loaded", 32'(remaining), 16);
        do_burst(16'h3000, 13'h0200, 1'b1, 8'd30);
        @(negedge clk);
        chk(remaining == 12'd0, "R11 new transfer completes", 32'(remaining), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule